// File: doc/BRIEF.md
# Collision-Aware Manchester Frame Receiver

This block sits on the receive side of a reader that polls a population of tags over a shared line. Every tag that answers drives its ID in Manchester code at the same time, and the line carries the wired-OR of all replies. The receiver watches the line, locks onto the start of a reply, and recovers one ID word. It also builds a parallel word with a 1 at each bit position where the replies disagreed. An upper-level search engine uses that word to choose the next query prefix.

The receiver is idle until it is armed. It then listens for the rising edge that opens a reply. A two-sample shift register detects that edge. The edge restarts a phase counter whose period equals one bit period. Each bit cell is sampled once at the quarter point and once at the three-quarter point. If the two halves differ, the bit is clean and takes the first-half level. If they match, the cell had no mid-bit transition and is marked as collided. When the last bit has been judged, the word and the collision flags are presented together with a one-cycle ready pulse. If no reply starts within a set number of cycles after arming, a one-cycle no-reply pulse is given instead.

Top module: `mcoll_rx`

## Requirements
- R1: After reset, `word_o` and `coll_o` are all zeros and both `ready_o` and `noreply_o` are low.
- R2: While armed and waiting, a line sample of 0 followed by a sample of 1 on the next clock opens a frame. The sample at 1 is frame sample 0. The first BIT_CYC samples form a start cell, which is discarded. WORD_W data cells of BIT_CYC samples each follow, most significant bit first.
- R3: Within each data cell, the line is read only at the samples with in-cell offsets BIT_CYC/4 and 3*BIT_CYC/4, counted from the frame's sample 0. Levels at every other offset have no effect on the result.
- R4: A cell whose first half is high and second half is low decodes as 1. A cell whose first half is low and second half is high decodes as 0. In both cases the cell's collision flag is 0.
- R5: A cell whose two samples are equal, both high or both low, sets its collision flag to 1 and its data bit to 1.
- R6: `ready_o` is high for exactly one cycle, after clock edge WORD_W*BIT_CYC + 3*BIT_CYC/4 + 2 counted from frame sample 0. From that edge, `word_o` and `coll_o` hold the new frame until the next ready pulse.
- R7: Bit i of `coll_o` refers to bit i of `word_o`. The first data cell received sets bit WORD_W-1. For example, collisions in bits 7, 5 and 1 of an 8-bit word give `coll_o` = 10100010.
- R8: If no frame opens within TMO_CYC cycles of the edge that registers `arm_i`, `noreply_o` pulses for one cycle after edge TMO_CYC counted from that edge. No ready pulse follows, and the receiver returns to idle.
- R9: While not armed, line activity is ignored. No pulse occurs and `word_o` and `coll_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, BIT_CYC cycles per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | One-cycle pulse: start waiting for a reply |
| line_i | input | 1 | Wired-OR Manchester line from the tags |
| word_o | output | WORD_W | Decoded ID word, collided bits read as 1 |
| coll_o | output | WORD_W | Collision flags, 1 where replies disagreed |
| ready_o | output | 1 | One-cycle pulse: new word and flags valid |
| noreply_o | output | 1 | One-cycle pulse: no reply before timeout |

## Verification
The bench builds the receiver with an 8-bit word, 16 clocks per bit and a 48-cycle timeout. The short timeout makes the no-reply pulse reachable within a few dozen cycles. With 16 clocks per bit, the quarter and three-quarter points fall on whole cycles that are easy to tell apart. In one stimulus run the line is inverted at every offset except the two sampling points, which exposes any sampling that is off by a single cycle. Reply sets of one, two and four tags show clean bits, partial collisions, all-bit collisions and identical tags. A start cell followed by a silent line exercises the equal-low case.

// File: rtl/mcoll_pkg.sv
package mcoll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LISTEN = 2'd1,
        ST_RECV   = 2'd2,
        ST_DONE   = 2'd3
    } rx_state_e;

endpackage

// File: rtl/mcoll_edge_watch.sv
module mcoll_edge_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_now_o,
    output logic rise_o
);
    typedef struct packed {
        logic [1:0] sh;
    } ew_t;

    ew_t q, d;

    always_comb begin
        d.sh       = {q.sh[0], line_i};
        line_now_o = q.sh[0];
        rise_o     = (q.sh == 2'b01);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sh: 2'b11};
        else        q <= d;
    end

    // R2: a detected rise means the line was high at the last edge
    p_rise_seen_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> $past(line_i));

endmodule

// File: rtl/mcoll_bit_clock.sv
module mcoll_bit_clock #(
    parameter int WORD_W  = 8,
    parameter int BIT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic half1_o,
    output logic half2_o,
    output logic last_o
);
    localparam int CNT_W = $clog2(BIT_CYC);
    localparam int IDX_W = $clog2(WORD_W + 1);
    localparam int Q1    = BIT_CYC / 4;
    localparam int Q3    = (3 * BIT_CYC) / 4;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } bc_t;

    bc_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.cnt = CNT_W'(1);
            d.idx = '0;
        end else if (run_i) begin
            if (q.cnt == CNT_W'(BIT_CYC - 1)) begin
                d.cnt = '0;
                d.idx = q.idx + IDX_W'(1);
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
        half1_o = run_i && (q.idx != '0) && (q.cnt == CNT_W'(Q1));
        half2_o = run_i && (q.idx != '0) && (q.cnt == CNT_W'(Q3));
        last_o  = (q.idx == IDX_W'(WORD_W));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3: each strobe lasts one cycle and the two never coincide
    p_half1_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        half1_o |=> !half1_o);
    p_half_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(half1_o && half2_o));

endmodule

// File: rtl/mcoll_bit_judge.sv
module mcoll_bit_judge #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              line_i,
    input  logic              half1_i,
    input  logic              half2_i,
    output logic [WORD_W-1:0] data_o,
    output logic [WORD_W-1:0] coll_o
);
    typedef struct packed {
        logic              first;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] coll;
    } bj_t;

    bj_t  q, d;
    logic same;

    always_comb begin
        d    = q;
        same = (q.first == line_i);
        if (clear_i) begin
            d.data  = '0;
            d.coll  = '0;
            d.first = 1'b0;
        end else begin
            if (half1_i) d.first = line_i;
            if (half2_i) begin
                d.data = {q.data[WORD_W-2:0], same ? 1'b1 : q.first};
                d.coll = {q.coll[WORD_W-2:0], same};
            end
        end
        data_o = q.data;
        coll_o = q.coll;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: a flagged cell always reads as 1
    p_coll_reads_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_o & ~data_o) == '0);

endmodule

// File: rtl/mcoll_rx.sv
module mcoll_rx
    import mcoll_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int BIT_CYC = 16,
    parameter int TMO_CYC = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              line_i,
    output logic [WORD_W-1:0] word_o,
    output logic [WORD_W-1:0] coll_o,
    output logic              ready_o,
    output logic              noreply_o
);
    localparam int WAIT_W = $clog2(TMO_CYC);

    typedef struct packed {
        rx_state_e         state;
        logic [WAIT_W-1:0] waitc;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] coll;
        logic              ready;
        logic              noreply;
    } top_t;

    top_t              q, d;
    logic              line_now, rise, half1, half2, last_bit, load, run;
    logic [WORD_W-1:0] jd_data, jd_coll;

    mcoll_edge_watch i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_i),
        .line_now_o (line_now),
        .rise_o     (rise)
    );

    mcoll_bit_clock #(.WORD_W(WORD_W), .BIT_CYC(BIT_CYC)) i_clock (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .run_i   (run),
        .half1_o (half1),
        .half2_o (half2),
        .last_o  (last_bit)
    );

    mcoll_bit_judge #(.WORD_W(WORD_W)) i_judge (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load),
        .line_i  (line_now),
        .half1_i (half1),
        .half2_i (half2),
        .data_o  (jd_data),
        .coll_o  (jd_coll)
    );

    always_comb begin
        d         = q;
        d.ready   = 1'b0;
        d.noreply = 1'b0;
        load      = 1'b0;
        run       = (q.state == ST_RECV);
        case (q.state)
            ST_IDLE: begin
                if (arm_i) begin
                    d.state = ST_LISTEN;
                    d.waitc = '0;
                end
            end
            ST_LISTEN: begin
                if (rise) begin
                    d.state = ST_RECV;
                    load    = 1'b1;
                end else if (q.waitc == WAIT_W'(TMO_CYC - 1)) begin
                    d.state   = ST_IDLE;
                    d.noreply = 1'b1;
                end else begin
                    d.waitc = q.waitc + WAIT_W'(1);
                end
            end
            ST_RECV: begin
                if (half2 && last_bit) d.state = ST_DONE;
            end
            ST_DONE: begin
                d.word  = jd_data;
                d.coll  = jd_coll;
                d.ready = 1'b1;
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
        word_o    = q.word;
        coll_o    = q.coll;
        ready_o   = q.ready;
        noreply_o = q.noreply;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= top_t'('0);
        else        q <= d;
    end

    // R6: ready is a single-cycle pulse
    p_ready_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);
    // R8: the two outcomes of one request never coincide
    p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && noreply_o));
    // R8: no-reply only comes out of the waiting state
    p_noreply_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        noreply_o |-> $past(q.state == ST_LISTEN));
    // R2: a reception starts only on a detected rise
    p_recv_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RECV && $past(q.state) == ST_LISTEN) |-> $past(rise));
    // R9: outputs are frozen while the receiver stays idle
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && $past(q.state) == ST_IDLE) |-> ($stable(word_o) && $stable(coll_o)));

endmodule

// File: tb/test_mcoll_rx.sv
module test_mcoll_rx;
    localparam int  W       = 8;
    localparam int  P       = 16;
    localparam int  TMO     = 48;
    localparam time CLK_PER = 10ns;
    localparam int  DONE_AT = W * P + (3 * P) / 4 + 2;
    localparam int  NVEC    = 8;

    // four tag IDs per vector (first tag in low byte) and the tag count
    localparam logic [4*W-1:0] TAGS [NVEC] = '{
        32'h0000_00A3, 32'h0000_005C, 32'hEC11_9BA3, 32'h0000_01A3,
        32'h0000_00FF, 32'h0000_0000, 32'h0000_9B9B, 32'h0000_0000 };
    localparam int NTAG [NVEC] = '{1, 1, 4, 2, 2, 1, 2, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic line = 1'b0;
    logic [W-1:0] word, coll;
    logic ready, noreply;
    int total = 0;
    int bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    mcoll_rx #(.WORD_W(W), .BIT_CYC(P), .TMO_CYC(TMO)) i_mcoll_rx (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .line_i(line),
        .word_o(word), .coll_o(coll), .ready_o(ready), .noreply_o(noreply));

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic tag_bit(input logic [4*W-1:0] tg, input int t, input int b);
        return tg[t*W + b];
    endfunction

    function automatic logic samp(input logic [4*W-1:0] tg, input int n, input int s, input bit skew);
        int  pos, j;
        logic v;
        if (s < P) return (s < P/2);
        if (s >= (W + 1) * P) return 1'b0;
        pos = s % P;
        j   = s / P - 1;
        v   = 1'b0;
        for (int t = 0; t < n; t++) begin
            if (pos < P/2) v = v | tag_bit(tg, t, W-1-j);
            else           v = v | ~tag_bit(tg, t, W-1-j);
        end
        if (skew && pos != P/4 && pos != (3*P)/4) v = ~v;
        return v;
    endfunction

    function automatic logic [W-1:0] exp_word(input logic [4*W-1:0] tg, input int n);
        logic [W-1:0] o = '0;
        if (n == 0) return '1;
        for (int t = 0; t < n; t++) o = o | tg[t*W +: W];
        return o;
    endfunction

    function automatic logic [W-1:0] exp_coll(input logic [4*W-1:0] tg, input int n);
        logic [W-1:0] o = '0;
        logic [W-1:0] a = '1;
        if (n == 0) return '1;
        for (int t = 0; t < n; t++) begin
            o = o | tg[t*W +: W];
            a = a & tg[t*W +: W];
        end
        return o & ~a;
    endfunction

    task automatic do_arm();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_frame(input logic [4*W-1:0] tg, input int n, input bit skew,
                             input bit want, input string req);
        int hits = 0;
        int at = -1;
        int nr = 0;
        for (int s = 0; s <= DONE_AT + 6; s++) begin
            @(negedge clk);
            if (s > 0) begin
                if (ready) begin hits++; at = s - 1; end
                if (noreply) nr++;
            end
            line = samp(tg, n, s, skew);
        end
        line = 1'b0;
        if (want) begin
            check({req, " R6 pulse count"}, hits, 1);
            check({req, " R6 pulse edge"}, at, DONE_AT);
        end else begin
            check({req, " R9 no pulse"}, hits, 0);
        end
        check({req, " R8 no stray no-reply"}, nr, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 word", int'(word), 0);
        check("R1 coll", int'(coll), 0);
        check("R1 ready", int'(ready), 0);
        check("R1 noreply", int'(noreply), 0);

        // table walk: R2 R4 R5 R7 via tag sets, expected from wired-OR rule
        for (int v = 0; v < NVEC; v++) begin
            do_arm();
            run_frame(TAGS[v], NTAG[v], 1'b0, 1'b1, $sformatf("vec%0d", v));
            check($sformatf("vec%0d R4 R5 R7 word", v), int'(word), int'(exp_word(TAGS[v], NTAG[v])));
            check($sformatf("vec%0d R5 R7 coll", v), int'(coll), int'(exp_coll(TAGS[v], NTAG[v])));
        end

        // R7 bit mapping example: flags at 7, 5, 1
        check("R7 example coll", int'(exp_coll(TAGS[3], 2)), 8'hA2);

        // R3 line inverted everywhere except the two sampling offsets
        do_arm();
        run_frame(32'h0000_006B, 1, 1'b1, 1'b1, "skew");
        check("R3 skew word", int'(word), 8'h6B);
        check("R3 skew coll", int'(coll), 0);

        // R9 activity with no arm is ignored, outputs held
        run_frame(32'h0000_005C, 1, 1'b0, 1'b0, "idle");
        check("R9 word held", int'(word), 8'h6B);
        check("R9 coll held", int'(coll), 0);

        // R8 timeout: arm and leave the line quiet
        begin
            int hits = 0;
            int at = -1;
            int rd = 0;
            @(negedge clk) arm = 1'b1;
            @(negedge clk) arm = 1'b0;
            for (int k = 1; k <= TMO + 4; k++) begin
                @(negedge clk);
                if (noreply) begin hits++; at = k; end
                if (ready) rd++;
            end
            check("R8 no-reply count", hits, 1);
            check("R8 no-reply edge", at, TMO);
            check("R8 no ready", rd, 0);
        end

        // R9 after timeout the receiver is idle again
        run_frame(32'h0000_0033, 1, 1'b0, 1'b0, "post-timeout");
        check("R9 word after timeout", int'(word), 8'h6B);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule